// File: doc/BRIEF.md
# Performance Request Register Resolver

This block holds the performance-request control words for a group of logical cores, plus one shared package-level word. Software writes and reads these 64-bit words through a simple register port. Each word carries a minimum level, a maximum level, a desired level, an energy-versus-performance preference and an activity-window hint. The stored words always read back exactly as written, apart from the fields the platform does not support.

A separate path turns the stored words into effective controls for each core. That path bounds the levels to the capability range supplied on input ports and resolves conflicting settings. It also decodes the activity window from its mantissa-and-decimal-exponent code into microseconds. Each core can set its own control bit to take all of its effective controls from the package word instead of its own word. The effective outputs are registered, and a frequency-selection engine downstream consumes them.

Top module: `perf_req_resolver`

## Requirements
- R1: Word layout: bits 7:0 minimum, 15:8 maximum, 23:16 desired, 31:24 preference, 41:32 activity window, 42 per-core package-select bit. A read returns exactly the last accepted value, unclipped. After reset each core word and the package word read 0x0000_0000_8000_FF00 (preference 80h, maximum FFh, all other fields 0).
- R2: A write with any of bits 63:43 set is rejected, and so is a package-word write with bit 42 set. A rejected write leaves the word unchanged and raises `reg_wr_err` for exactly the cycle after the write. An accepted write, or no write, leaves `reg_wr_err` low.
- R3: `field_sup` bit 0 marks minimum as supported, bit 1 maximum, bit 2 desired, bit 3 preference and bit 4 window. An unsupported field reads as zero, and a write does not change it. When the field becomes supported again, it reads its earlier value.
- R4: When a core's bit 42 is set, that core's effective controls come from the package word. Other cores keep their own words.
- R5: The effective minimum and maximum are each clamped to [`cap_lo`, `cap_hi`]. If the clamped maximum is below the clamped minimum, the effective maximum is raised to the effective minimum. An unsupported minimum is taken as `cap_lo`, and an unsupported maximum as `cap_hi`.
- R6: An effective desired level of zero means autonomous selection and stays zero. A nonzero desired level is clamped to [effective minimum, effective maximum]. An unsupported desired level counts as zero.
- R7: When the effective minimum equals the effective maximum, `eff_pinned` is high and the effective desired level equals that value.
- R8: When the preference field is unsupported, the effective preference equals `epb_level`. Otherwise it equals the stored field.
- R9: The window code is decoded as mantissa (bits 38:32) times 10 to the power of the exponent (bits 41:39), in microseconds, and saturates at the all-ones value of `WIN_W` bits. For example, code 0x3FF gives 1,270,000,000.
- R10: The decoded window is output only when the effective desired level is zero. Otherwise `eff_win_us` is zero. An unsupported window field counts as zero.
- R11: The effective outputs show a written value from the second rising clock edge after the write. The first edge updates the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the addressed word |
| reg_pkg_sel | input | 1 | 1 addresses the package word, 0 a core word |
| reg_core_sel | input | CIDX_W | Core index when reg_pkg_sel is 0 |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data of the addressed word (combinational) |
| reg_wr_err | output | 1 | Pulse the cycle after a rejected write |
| field_sup | input | 5 | Field support mask |
| cap_lo | input | 8 | Lowest level the core can run |
| cap_hi | input | 8 | Highest level the core can run |
| epb_level | input | 8 | Fallback energy preference |
| eff_min | output | 8*N_CORES | Effective minimum per core |
| eff_max | output | 8*N_CORES | Effective maximum per core |
| eff_des | output | 8*N_CORES | Effective desired level per core |
| eff_epp | output | 8*N_CORES | Effective energy preference per core |
| eff_win_us | output | WIN_W*N_CORES | Decoded activity window per core, in microseconds |
| eff_pinned | output | N_CORES | Minimum equals maximum per core |

## Verification
The hardest case to reach is a write that is ignored. The write's effect cannot be seen while the field is unsupported, because the field then reads as zero. The stimulus first withdraws support for the preference field and writes a new preference. It then restores support and reads the word. Only the earlier value reading back shows that the write was dropped. Package redirection is also hard to reach: the package word must be loaded first, and only then does a core set its select bit. At that point the outputs of the two cores must differ, while the first-edge sample shows the old values for one more cycle.

// File: rtl/perf_req_pkg.sv
package perf_req_pkg;

    localparam int LVL_W  = 8;
    localparam int WCODE_W = 10;

    localparam int SUP_MIN = 0;
    localparam int SUP_MAX = 1;
    localparam int SUP_DES = 2;
    localparam int SUP_EPP = 3;
    localparam int SUP_WIN = 4;
    localparam int SUP_N   = 5;

    typedef struct packed {
        logic               pkg_ctl;
        logic [WCODE_W-1:0] pwin;
        logic [LVL_W-1:0]   pepp;
        logic [LVL_W-1:0]   pdes;
        logic [LVL_W-1:0]   pmax;
        logic [LVL_W-1:0]   pmin;
    } req_t;

    localparam int REQ_W = $bits(req_t);

    function automatic req_t field_mask(input logic [SUP_N-1:0] sup, input logic ctl);
        req_t m;
        m.pkg_ctl = ctl;
        m.pwin    = {WCODE_W{sup[SUP_WIN]}};
        m.pepp    = {LVL_W{sup[SUP_EPP]}};
        m.pdes    = {LVL_W{sup[SUP_DES]}};
        m.pmax    = {LVL_W{sup[SUP_MAX]}};
        m.pmin    = {LVL_W{sup[SUP_MIN]}};
        return m;
    endfunction

    function automatic req_t req_reset();
        req_t r;
        r      = '0;
        r.pepp = 8'h80;
        r.pmax = 8'hFF;
        return r;
    endfunction

    function automatic logic [LVL_W-1:0] clamp(input logic [LVL_W-1:0] x,
                                               input logic [LVL_W-1:0] lo,
                                               input logic [LVL_W-1:0] hi);
        if (x < lo)      return lo;
        else if (x > hi) return (hi < lo) ? lo : hi;
        else             return x;
    endfunction

    function automatic logic [63:0] pow10(input logic [2:0] e);
        logic [63:0] r;
        r = 64'd1;
        for (int k = 0; k < 7; k++) begin
            if (k < int'(e)) r = r * 64'd10;
        end
        return r;
    endfunction

endpackage

// File: rtl/perf_win_decode.sv
module perf_win_decode
    import perf_req_pkg::*;
#(
    parameter int WIN_W = 32
) (
    input  logic [WCODE_W-1:0] code,
    output logic [WIN_W-1:0]   us
);
    localparam logic [63:0] SAT_V = (64'd1 << WIN_W) - 64'd1;

    logic [63:0] prod;

    always_comb begin
        prod = {57'd0, code[6:0]} * pow10(code[9:7]);
        if (prod > SAT_V) us = {WIN_W{1'b1}};
        else              us = prod[WIN_W-1:0];
    end
endmodule

// File: rtl/perf_clip.sv
module perf_clip
    import perf_req_pkg::*;
(
    input  logic [SUP_N-1:0]   sup,
    input  logic [LVL_W-1:0]   cap_lo,
    input  logic [LVL_W-1:0]   cap_hi,
    input  logic [LVL_W-1:0]   epb,
    input  logic [LVL_W-1:0]   r_min,
    input  logic [LVL_W-1:0]   r_max,
    input  logic [LVL_W-1:0]   r_des,
    input  logic [LVL_W-1:0]   r_epp,
    input  logic [WCODE_W-1:0] r_win,
    output logic [LVL_W-1:0]   e_min,
    output logic [LVL_W-1:0]   e_max,
    output logic [LVL_W-1:0]   e_des,
    output logic [LVL_W-1:0]   e_epp,
    output logic               e_pin,
    output logic [WCODE_W-1:0] e_wcode
);
    logic [LVL_W-1:0]   s_min, s_max, s_des, c_max;
    logic [WCODE_W-1:0] s_win;

    always_comb begin
        s_min = sup[SUP_MIN] ? r_min : cap_lo;
        s_max = sup[SUP_MAX] ? r_max : cap_hi;
        s_des = sup[SUP_DES] ? r_des : '0;
        s_win = sup[SUP_WIN] ? r_win : '0;
        e_epp = sup[SUP_EPP] ? r_epp : epb;

        e_min = clamp(s_min, cap_lo, cap_hi);
        c_max = clamp(s_max, cap_lo, cap_hi);
        e_max = (c_max < e_min) ? e_min : c_max;
        e_pin = (e_min == e_max);

        if (e_pin)              e_des = e_min;
        else if (s_des == '0)   e_des = '0;
        else                    e_des = clamp(s_des, e_min, e_max);

        e_wcode = (e_des == '0) ? s_win : '0;
    end
endmodule

// File: rtl/perf_req_resolver.sv
module perf_req_resolver
    import perf_req_pkg::*;
#(
    parameter  int N_CORES = 2,
    parameter  int WIN_W   = 32,
    localparam int CIDX_W  = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_wr,
    input  logic                       reg_pkg_sel,
    input  logic [CIDX_W-1:0]          reg_core_sel,
    input  logic [63:0]                reg_wdata,
    output logic [63:0]                reg_rdata,
    output logic                       reg_wr_err,
    input  logic [SUP_N-1:0]           field_sup,
    input  logic [LVL_W-1:0]           cap_lo,
    input  logic [LVL_W-1:0]           cap_hi,
    input  logic [LVL_W-1:0]           epb_level,
    output logic [N_CORES*LVL_W-1:0]   eff_min,
    output logic [N_CORES*LVL_W-1:0]   eff_max,
    output logic [N_CORES*LVL_W-1:0]   eff_des,
    output logic [N_CORES*LVL_W-1:0]   eff_epp,
    output logic [N_CORES*WIN_W-1:0]   eff_win_us,
    output logic [N_CORES-1:0]         eff_pinned
);
    localparam int RSV_W = 64 - REQ_W;

    typedef struct packed {
        req_t [N_CORES-1:0]              core;
        req_t                            pkg;
        logic                            err;
        logic [N_CORES-1:0][LVL_W-1:0]   emin;
        logic [N_CORES-1:0][LVL_W-1:0]   emax;
        logic [N_CORES-1:0][LVL_W-1:0]   edes;
        logic [N_CORES-1:0][LVL_W-1:0]   eepp;
        logic [N_CORES-1:0][WIN_W-1:0]   ewin;
        logic [N_CORES-1:0]              pin;
    } state_t;

    function automatic state_t state_reset();
        state_t s;
        s     = '0;
        s.pkg = req_reset();
        for (int i = 0; i < N_CORES; i++) s.core[i] = req_reset();
        return s;
    endfunction

    state_t st_d, st_q;

    logic [LVL_W-1:0]   c_min   [N_CORES];
    logic [LVL_W-1:0]   c_max   [N_CORES];
    logic [LVL_W-1:0]   c_des   [N_CORES];
    logic [LVL_W-1:0]   c_epp   [N_CORES];
    logic               c_pin   [N_CORES];
    logic [WCODE_W-1:0] c_wcode [N_CORES];
    logic [WIN_W-1:0]   c_win   [N_CORES];

    // per-core resolution path
    for (genvar i = 0; i < N_CORES; i++) begin : g_core
        req_t src;
        assign src = st_q.core[i].pkg_ctl ? st_q.pkg : st_q.core[i];

        perf_clip u_clip (
            .sup     (field_sup),
            .cap_lo  (cap_lo),
            .cap_hi  (cap_hi),
            .epb     (epb_level),
            .r_min   (src.pmin),
            .r_max   (src.pmax),
            .r_des   (src.pdes),
            .r_epp   (src.pepp),
            .r_win   (src.pwin),
            .e_min   (c_min[i]),
            .e_max   (c_max[i]),
            .e_des   (c_des[i]),
            .e_epp   (c_epp[i]),
            .e_pin   (c_pin[i]),
            .e_wcode (c_wcode[i])
        );

        perf_win_decode #(.WIN_W(WIN_W)) u_dec (
            .code (c_wcode[i]),
            .us   (c_win[i])
        );

        assign eff_min[i*LVL_W +: LVL_W]    = st_q.emin[i];
        assign eff_max[i*LVL_W +: LVL_W]    = st_q.emax[i];
        assign eff_des[i*LVL_W +: LVL_W]    = st_q.edes[i];
        assign eff_epp[i*LVL_W +: LVL_W]    = st_q.eepp[i];
        assign eff_win_us[i*WIN_W +: WIN_W] = st_q.ewin[i];
        assign eff_pinned[i]                = st_q.pin[i];
    end

    logic  wr_bad;
    logic  sel_ok;
    req_t  wmask;
    req_t  wnew;
    req_t  rd_word;

    always_comb begin
        st_d   = st_q;
        sel_ok = (int'(reg_core_sel) < N_CORES);
        wr_bad = (|reg_wdata[63:REQ_W]) | (reg_pkg_sel & reg_wdata[REQ_W-1]);
        wmask  = field_mask(field_sup, ~reg_pkg_sel);
        wnew   = req_t'(reg_wdata[REQ_W-1:0]);

        st_d.err = reg_wr & wr_bad;
        if (reg_wr && !wr_bad) begin
            if (reg_pkg_sel)
                st_d.pkg = (wnew & wmask) | (st_q.pkg & ~wmask);
            else if (sel_ok)
                st_d.core[reg_core_sel] = (wnew & wmask) | (st_q.core[reg_core_sel] & ~wmask);
        end

        for (int i = 0; i < N_CORES; i++) begin
            st_d.emin[i] = c_min[i];
            st_d.emax[i] = c_max[i];
            st_d.edes[i] = c_des[i];
            st_d.eepp[i] = c_epp[i];
            st_d.ewin[i] = c_win[i];
            st_d.pin[i]  = c_pin[i];
        end

        if (reg_pkg_sel)  rd_word = st_q.pkg;
        else if (sel_ok)  rd_word = st_q.core[reg_core_sel];
        else              rd_word = '0;
        reg_rdata = {{RSV_W{1'b0}}, rd_word & field_mask(field_sup, 1'b1)};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= state_reset();
        else        st_q <= st_d;
    end

    assign reg_wr_err = st_q.err;
endmodule

// File: rtl/perf_req_resolver_chk.sv
module perf_req_resolver_chk
#(
    parameter int N_CORES = 2,
    parameter int WIN_W   = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     reg_wr,
    input logic [63:0]              reg_wdata,
    input logic                     reg_wr_err,
    input logic [7:0]               cap_lo,
    input logic [7:0]               cap_hi,
    input logic [N_CORES*8-1:0]     eff_min,
    input logic [N_CORES*8-1:0]     eff_max,
    input logic [N_CORES*8-1:0]     eff_des,
    input logic [N_CORES*WIN_W-1:0] eff_win_us,
    input logic [N_CORES-1:0]       eff_pinned
);
    p_rsv_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (|reg_wdata[63:43])) |=> reg_wr_err);

    p_err_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> !reg_wr_err);

    for (genvar i = 0; i < N_CORES; i++) begin : g_chk
        p_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
            eff_max[i*8 +: 8] >= eff_min[i*8 +: 8]);

        p_bounds_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (cap_lo <= cap_hi) |=>
            (eff_min[i*8 +: 8] >= $past(cap_lo) && eff_max[i*8 +: 8] <= $past(cap_hi)));

        p_des_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (eff_des[i*8 +: 8] != 8'd0) |->
            (eff_des[i*8 +: 8] >= eff_min[i*8 +: 8] && eff_des[i*8 +: 8] <= eff_max[i*8 +: 8]));

        p_pinned_r7: assert property (@(posedge clk) disable iff (!rst_n)
            eff_pinned[i] |-> (eff_des[i*8 +: 8] == eff_min[i*8 +: 8]));

        p_win_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (eff_win_us[i*WIN_W +: WIN_W] != '0) |-> (eff_des[i*8 +: 8] == 8'd0));
    end
endmodule

bind perf_req_resolver perf_req_resolver_chk #(.N_CORES(N_CORES), .WIN_W(WIN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .reg_wr_err (reg_wr_err),
    .cap_lo     (cap_lo),
    .cap_hi     (cap_hi),
    .eff_min    (eff_min),
    .eff_max    (eff_max),
    .eff_des    (eff_des),
    .eff_win_us (eff_win_us),
    .eff_pinned (eff_pinned)
);

// File: tb/sim_perf_req_resolver.sv
`timescale 1ns/1ps
module sim_perf_req_resolver;
    localparam int NC = 2;
    localparam int WW = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_wr = 1'b0;
    logic            reg_pkg_sel = 1'b0;
    logic [0:0]      reg_core_sel = '0;
    logic [63:0]     reg_wdata = '0;
    logic [63:0]     reg_rdata;
    logic            reg_wr_err;
    logic [4:0]      field_sup = 5'b11111;
    logic [7:0]      cap_lo = 8'd10;
    logic [7:0]      cap_hi = 8'd200;
    logic [7:0]      epb_level = 8'h33;
    logic [NC*8-1:0] eff_min, eff_max, eff_des, eff_epp;
    logic [NC*WW-1:0] eff_win_us;
    logic [NC-1:0]   eff_pinned;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    perf_req_resolver #(.N_CORES(NC), .WIN_W(WW)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_pkg_sel(reg_pkg_sel),
        .reg_core_sel(reg_core_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_wr_err(reg_wr_err), .field_sup(field_sup), .cap_lo(cap_lo),
        .cap_hi(cap_hi), .epb_level(epb_level), .eff_min(eff_min), .eff_max(eff_max),
        .eff_des(eff_des), .eff_epp(eff_epp), .eff_win_us(eff_win_us),
        .eff_pinned(eff_pinned)
    );

    // {wdata, min, max, des, epp, win_us, pinned}
    localparam int VW = 64 + 32 + 32 + 1;
    localparam logic [VW-1:0] VEC [9] = '{
        {64'h0000_0105_4000_6414, 8'd20,  8'd100, 8'd0,   8'h40, 32'd500,        1'b0},
        {64'h0000_0000_8000_FA05, 8'd10,  8'd200, 8'd0,   8'h80, 32'd0,          1'b0},
        {64'h0000_0083_8000_1E32, 8'd50,  8'd50,  8'd50,  8'h80, 32'd0,          1'b1},
        {64'h0000_0007_8096_6414, 8'd20,  8'd100, 8'd100, 8'h80, 32'd0,          1'b0},
        {64'h0000_0000_800F_6414, 8'd20,  8'd100, 8'd20,  8'h80, 32'd0,          1'b0},
        {64'h0000_0000_803C_6414, 8'd20,  8'd100, 8'd60,  8'h80, 32'd0,          1'b0},
        {64'h0000_0000_8000_0000, 8'd10,  8'd10,  8'd10,  8'h80, 32'd0,          1'b1},
        {64'h0000_03FF_8000_6414, 8'd20,  8'd100, 8'd0,   8'h80, 32'd1270000000, 1'b0},
        {64'h0000_0001_8000_6414, 8'd20,  8'd100, 8'd0,   8'h80, 32'd1,          1'b0}
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input bit pkg, input int core, input logic [63:0] d);
        @(negedge clk);
        reg_pkg_sel  = pkg;
        reg_core_sel = core[0:0];
        reg_wdata    = d;
        reg_wr       = 1'b1;
        @(negedge clk);
        reg_wr       = 1'b0;
    endtask

    task automatic sel(input bit pkg, input int core);
        reg_pkg_sel  = pkg;
        reg_core_sel = core[0:0];
        #1;
    endtask

    function automatic logic [7:0] lv(input logic [NC*8-1:0] v, input int c);
        return v[c*8 +: 8];
    endfunction

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset read value, R5 reset effective values
        sel(0, 0);
        chk(reg_rdata == 64'h0000_0000_8000_FF00, "R1 reset core word", reg_rdata, 64'h0000_0000_8000_FF00);
        sel(1, 0);
        chk(reg_rdata == 64'h0000_0000_8000_FF00, "R1 reset pkg word", reg_rdata, 64'h0000_0000_8000_FF00);
        chk(lv(eff_min, 0) == 8'd10 && lv(eff_max, 0) == 8'd200, "R5 reset clamp",
            {lv(eff_min, 0), lv(eff_max, 0)}, {8'd10, 8'd200});

        // vector walk on core 0 (R1 R5 R6 R7 R9 R10)
        for (int v = 0; v < 9; v++) begin
            logic [VW-1:0] e;
            e = VEC[v];
            wr(0, 0, e[128:65]);
            chk(reg_wr_err == 1'b0, "R2 accepted write no error", {63'd0, reg_wr_err}, 64'd0);
            sel(0, 0);
            chk(reg_rdata == e[128:65], "R1 readback unclipped", reg_rdata, e[128:65]);
            @(negedge clk);
            chk(lv(eff_min, 0) == e[64:57], "R5 eff min", lv(eff_min, 0), e[64:57]);
            chk(lv(eff_max, 0) == e[56:49], "R5 eff max", lv(eff_max, 0), e[56:49]);
            chk(lv(eff_des, 0) == e[48:41], "R6 eff desired", lv(eff_des, 0), e[48:41]);
            chk(lv(eff_epp, 0) == e[40:33], "R8 eff preference", lv(eff_epp, 0), e[40:33]);
            chk(eff_win_us[31:0] == e[32:1], "R9 R10 window decode", eff_win_us[31:0], e[32:1]);
            chk(eff_pinned[0] == e[0], "R7 pinned", eff_pinned[0], e[0]);
        end

        // R4 package redirection, R11 timing
        wr(1, 0, 64'h0000_0082_5500_3C1E);
        wr(0, 1, 64'h0000_0400_0000_0000);
        chk(lv(eff_min, 1) == 8'd10, "R11 old value after first edge", lv(eff_min, 1), 8'd10);
        @(negedge clk);
        chk(lv(eff_min, 1) == 8'd30 && lv(eff_max, 1) == 8'd60, "R4 core1 from pkg",
            {lv(eff_min, 1), lv(eff_max, 1)}, {8'd30, 8'd60});
        chk(lv(eff_epp, 1) == 8'h55, "R4 pkg preference", lv(eff_epp, 1), 8'h55);
        chk(eff_win_us[63:32] == 32'd20, "R4 R9 pkg window", eff_win_us[63:32], 32'd20);
        chk(lv(eff_min, 0) == 8'd20, "R4 core0 unaffected", lv(eff_min, 0), 8'd20);
        sel(0, 1);
        chk(reg_rdata == 64'h0000_0400_0000_0000, "R1 R4 core1 readback", reg_rdata, 64'h0000_0400_0000_0000);

        // R2 rejection
        wr(0, 0, 64'h0000_0800_0000_1111);
        chk(reg_wr_err == 1'b1, "R2 reserved bit error", {63'd0, reg_wr_err}, 64'd1);
        sel(0, 0);
        chk(reg_rdata == 64'h0000_0001_8000_6414, "R2 word kept", reg_rdata, 64'h0000_0001_8000_6414);
        @(negedge clk);
        chk(reg_wr_err == 1'b0, "R2 error single cycle", {63'd0, reg_wr_err}, 64'd0);
        wr(1, 0, 64'h0000_0400_0000_0000);
        chk(reg_wr_err == 1'b1, "R2 pkg bit42 error", {63'd0, reg_wr_err}, 64'd1);
        sel(1, 0);
        chk(reg_rdata == 64'h0000_0082_5500_3C1E, "R2 pkg word kept", reg_rdata, 64'h0000_0082_5500_3C1E);

        // R3 / R8 unsupported preference
        field_sup = 5'b10111;
        epb_level = 8'h33;
        repeat (2) @(negedge clk);
        chk(lv(eff_epp, 0) == 8'h33, "R8 fallback preference", lv(eff_epp, 0), 8'h33);
        sel(0, 0);
        chk(reg_rdata[31:24] == 8'h00, "R3 unsupported reads zero", reg_rdata[31:24], 8'h00);
        wr(0, 0, 64'h0000_0001_1100_6414);
        field_sup = 5'b11111;
        repeat (2) @(negedge clk);
        sel(0, 0);
        chk(reg_rdata == 64'h0000_0001_8000_6414, "R3 unsupported write ignored", reg_rdata, 64'h0000_0001_8000_6414);
        chk(lv(eff_epp, 0) == 8'h80, "R8 stored preference", lv(eff_epp, 0), 8'h80);

        // R5 unsupported min/max take capability bounds, R10 unsupported window
        field_sup = 5'b01100;
        repeat (2) @(negedge clk);
        chk(lv(eff_min, 0) == 8'd10 && lv(eff_max, 0) == 8'd200, "R5 unsupported min max",
            {lv(eff_min, 0), lv(eff_max, 0)}, {8'd10, 8'd200});
        chk(eff_win_us[31:0] == 32'd0, "R10 unsupported window", eff_win_us[31:0], 32'd0);
        field_sup = 5'b11111;

        done = 1;
        summary();
        $finish;
    end
endmodule